// File: doc/BRIEF.md
# Glitch-Free System Clock Source Switch

This block chooses the clock that drives the system between two free-running inputs, a crystal oscillator clock and a PLL clock. Software holds a source-select bit and a PLL-enable bit; a self-clock request from the clock-monitor logic can force the PLL as source. A change of source runs a break-before-make handshake: the old source's gate closes through a synchroniser clocked by the old source, and only after that does the new source's gate open through a synchroniser clocked by the new source. Between the two, no edge reaches the system clock.

The block also makes a bus clock at half the system clock. It stops the system clock in stop mode. It provides per-timer oscillator clock gates, each qualified by an enable, a halt-in-wait option and a keep-running-in-stop option. The control register lives in the oscillator domain. A select change that arrives while a switch is in flight is held off until that switch is over.

Top module: `ckm_clk_switch`

## Requirements
- R1: Once no switch is in progress, `sys_clk` follows `clk_osc` when the target is the oscillator (`src_pll` = 0) and follows `clk_pll` when the target is the PLL (`src_pll` = 1); the target is `sel_pll` = 1 for PLL, 0 for oscillator.
- R2: `pll_on` stays 1 while the PLL is the target, the switch target or still acknowledged, whatever `pll_en_req` is; with the oscillator settled and `pll_en_req` = 0, `pll_on` falls to 0 and returns to 1 one cycle after `pll_en_req` = 1.
- R3: The two source gates are never open together, and `sys_clk` never shows a high or low phase shorter than the shorter input half-period.
- R4: `busy` rises in the `clk_osc` cycle after the target register changes and falls within 12 `clk_osc` cycles (2 oscillator plus 2 PLL synchroniser stages and a 2-stage acknowledge, PLL faster than oscillator).
- R5: A `sel_pll` change made while `busy` = 1 leaves the target unchanged until `busy` falls, and it is then applied on the next `clk_osc` edge, starting a second switch.
- R6: `self_clk_req` = 1 makes the PLL the target regardless of `sel_pll`.
- R7: `bus_clk` toggles on every rising `sys_clk` edge, giving one `bus_clk` rising edge per two `sys_clk` rising edges.
- R8: With `stop_req` = 1, `sys_clk` is held low within two `clk_osc` cycles and `bus_clk` holds its level; both resume when `stop_req` returns to 0.
- R9: `tmr_clk[i]` follows `clk_osc` when `tmr_en[i]` & !(`wait_req` & `tmr_wait_off[i]`) & !(`stop_req` & !`tmr_stop_keep[i]`) is 1, and is held low otherwise, with the gate updated on falling `clk_osc` edges.
- R10: During and after synchronous reset (`rst` = 1 on `clk_osc`), the oscillator is the source, `busy` = 0, `pll_on` = 1 and `bus_clk` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock; clocks the control register |
| clk_pll | input | 1 | PLL output clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_pll | input | 1 | Source select bit: 1 PLL, 0 oscillator |
| pll_en_req | input | 1 | Requested PLL enable bit |
| self_clk_req | input | 1 | Self-clock request, forces PLL as source |
| stop_req | input | 1 | Stop-mode indication |
| wait_req | input | 1 | Wait-mode indication |
| tmr_en | input | TMR_N | Per-timer oscillator clock enable |
| tmr_wait_off | input | TMR_N | Per-timer: halt clock in wait mode |
| tmr_stop_keep | input | TMR_N | Per-timer: keep clock running in stop mode |
| sys_clk | output | 1 | System (core) clock |
| bus_clk | output | 1 | Bus clock, system clock divided by 2 |
| tmr_clk | output | TMR_N | Gated oscillator clocks for the timers |
| busy | output | 1 | Source switch in progress |
| src_pll | output | 1 | PLL is the settled source |
| pll_on | output | 1 | Effective PLL enable |

## Verification
The checker watches every oscillator cycle for the handshake invariants: the gates are never open together, the PLL stays enabled while it is the target, the target does not move during a switch, the self-clock request forces the PLL, the stop gate closes and a switch ends within its bound. What `sys_clk` actually carries only shows up in the bench scenarios. That covers which input it follows after each switch, that no phase is ever short, the divide-by-two ratio of the bus clock under both sources, the freeze in stop and the per-timer gate decoding under random mode bits. The deferred second switch and the reset values are shown by directed sequences.

// File: rtl/ckm_pkg.sv
`timescale 1ns/1ps
package ckm_pkg;

    typedef enum logic {
        SRC_OSC = 1'b0,
        SRC_PLL = 1'b1
    } src_e;

    typedef struct packed {
        logic en;
        logic wait_off;
        logic stop_keep;
    } tmr_cfg_t;

    function automatic logic tmr_allow(tmr_cfg_t cfg, logic wt, logic st);
        return cfg.en & ~(wt & cfg.wait_off) & ~(st & ~cfg.stop_keep);
    endfunction

    function automatic logic switch_busy(src_e tgt, logic osc_on, logic pll_ack);
        if (tgt == SRC_PLL)
            return osc_on | ~pll_ack;
        return ~osc_on | pll_ack;
    endfunction

endpackage

// File: rtl/ckm_sync.sv
`timescale 1ns/1ps
module ckm_sync #(
    parameter int STAGES  = 2,
    parameter bit FALL    = 1'b1,
    parameter bit RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (FALL) begin : g_fall
            always_ff @(negedge clk) begin
                if (rst) chain <= {STAGES{RST_VAL}};
                else     chain <= {chain[STAGES-2:0], d};
            end
        end else begin : g_rise
            always_ff @(posedge clk) begin
                if (rst) chain <= {STAGES{RST_VAL}};
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/ckm_ctl.sv
`timescale 1ns/1ps
module ckm_ctl
    import ckm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sel_pll,
    input  logic self_req,
    input  logic pll_en_req,
    input  logic osc_on,
    input  logic pll_ack,
    output src_e tgt,
    output logic busy,
    output logic pll_keep
);
    src_e tgt_d;
    src_e req_src;

    assign busy    = switch_busy(tgt, osc_on, pll_ack);
    assign req_src = (sel_pll | self_req) ? SRC_PLL : SRC_OSC;
    assign tgt_d   = busy ? tgt : req_src;

    always_ff @(posedge clk) begin
        if (rst) begin
            tgt      <= SRC_OSC;
            pll_keep <= 1'b1;
        end else begin
            tgt      <= tgt_d;
            pll_keep <= pll_en_req | (tgt_d == SRC_PLL) | (tgt == SRC_PLL) | pll_ack;
        end
    end
endmodule

// File: rtl/ckm_tmr_gate.sv
`timescale 1ns/1ps
module ckm_tmr_gate
    import ckm_pkg::*;
#(
    parameter int TMR_N = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [TMR_N-1:0] en,
    input  logic [TMR_N-1:0] wait_off,
    input  logic [TMR_N-1:0] stop_keep,
    input  logic             wait_req,
    input  logic             stop_req,
    output logic [TMR_N-1:0] gclk
);
    logic [TMR_N-1:0] open_q;

    generate
        for (genvar i = 0; i < TMR_N; i++) begin : g_tmr
            tmr_cfg_t cfg;
            assign cfg = '{en: en[i], wait_off: wait_off[i], stop_keep: stop_keep[i]};

            always_ff @(negedge clk) begin
                if (rst) open_q[i] <= 1'b0;
                else     open_q[i] <= tmr_allow(cfg, wait_req, stop_req);
            end

            assign gclk[i] = clk & open_q[i];
        end
    endgenerate
endmodule

// File: rtl/ckm_clk_switch.sv
`timescale 1ns/1ps
module ckm_clk_switch
    import ckm_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int TMR_N       = 2
) (
    input  logic             clk_osc,
    input  logic             clk_pll,
    input  logic             rst,
    input  logic             sel_pll,
    input  logic             pll_en_req,
    input  logic             self_clk_req,
    input  logic             stop_req,
    input  logic             wait_req,
    input  logic [TMR_N-1:0] tmr_en,
    input  logic [TMR_N-1:0] tmr_wait_off,
    input  logic [TMR_N-1:0] tmr_stop_keep,
    output logic             sys_clk,
    output logic             bus_clk,
    output logic [TMR_N-1:0] tmr_clk,
    output logic             busy,
    output logic             src_pll,
    output logic             pll_on
);
    localparam int ACK_STAGES = SYNC_STAGES;

    src_e tgt;
    logic osc_on;
    logic pll_gate;
    logic pll_ack;
    logic osc_d;
    logic pll_d;
    logic osc_run;
    logic pll_run;
    logic bus_q;

    // Control register and status, oscillator domain
    ckm_ctl u_ctl (
        .clk       (clk_osc),
        .rst       (rst),
        .sel_pll   (sel_pll),
        .self_req  (self_clk_req),
        .pll_en_req(pll_en_req),
        .osc_on    (osc_on),
        .pll_ack   (pll_ack),
        .tgt       (tgt),
        .busy      (busy),
        .pll_keep  (pll_on)
    );

    // Break-before-make: each side opens only when the other is seen closed
    assign osc_d = (tgt == SRC_OSC) & ~pll_gate;
    assign pll_d = (tgt == SRC_PLL) & ~osc_on;

    ckm_sync #(.STAGES(SYNC_STAGES), .FALL(1'b1), .RST_VAL(1'b1)) u_osc_sync (
        .clk(clk_osc), .rst(rst), .d(osc_d), .q(osc_on)
    );

    ckm_sync #(.STAGES(SYNC_STAGES), .FALL(1'b1), .RST_VAL(1'b0)) u_pll_sync (
        .clk(clk_pll), .rst(rst), .d(pll_d), .q(pll_gate)
    );

    ckm_sync #(.STAGES(ACK_STAGES), .FALL(1'b0), .RST_VAL(1'b0)) u_ack_sync (
        .clk(clk_osc), .rst(rst), .d(pll_gate), .q(pll_ack)
    );

    // Stop-mode gates, updated while each clock is low
    always_ff @(negedge clk_osc) begin
        if (rst) osc_run <= 1'b1;
        else     osc_run <= ~stop_req;
    end

    always_ff @(negedge clk_pll) begin
        if (rst) pll_run <= 1'b1;
        else     pll_run <= ~stop_req;
    end

    assign sys_clk = (clk_osc & osc_on & osc_run) | (clk_pll & pll_gate & pll_run);

    // Bus clock divider
    always_ff @(posedge sys_clk) begin
        if (rst) bus_q <= 1'b0;
        else     bus_q <= ~bus_q;
    end

    assign bus_clk = bus_q;
    assign src_pll = (tgt == SRC_PLL) & ~busy;

    ckm_tmr_gate #(.TMR_N(TMR_N)) u_tmr (
        .clk      (clk_osc),
        .rst      (rst),
        .en       (tmr_en),
        .wait_off (tmr_wait_off),
        .stop_keep(tmr_stop_keep),
        .wait_req (wait_req),
        .stop_req (stop_req),
        .gclk     (tmr_clk)
    );
endmodule

// File: rtl/ckm_clk_switch_chk.sv
`timescale 1ns/1ps
module ckm_clk_switch_chk #(
    parameter int BUSY_MAX = 12
) (
    input logic clk_osc,
    input logic rst,
    input logic osc_on,
    input logic pll_gate,
    input logic busy,
    input logic tgt_pll,
    input logic pll_on,
    input logic self_clk_req,
    input logic stop_req,
    input logic osc_run
);
    logic [7:0] busy_cnt;

    always_ff @(posedge clk_osc) begin
        if (rst)                   busy_cnt <= 8'd0;
        else if (!busy)            busy_cnt <= 8'd0;
        else if (busy_cnt != 8'hff) busy_cnt <= busy_cnt + 8'd1;
    end

    p_one_gate_r3: assert property (@(posedge clk_osc) disable iff (rst)
        !(osc_on && pll_gate));

    p_pll_kept_r2: assert property (@(posedge clk_osc) disable iff (rst)
        tgt_pll |-> pll_on);

    p_tgt_held_r5: assert property (@(posedge clk_osc) disable iff (rst)
        busy |=> $stable(tgt_pll));

    p_self_pll_r6: assert property (@(posedge clk_osc) disable iff (rst)
        (self_clk_req && !busy) |=> tgt_pll);

    p_stop_gate_r8: assert property (@(posedge clk_osc) disable iff (rst)
        (stop_req && $past(stop_req)) |-> !osc_run);

    p_switch_bound_r4: assert property (@(posedge clk_osc) disable iff (rst)
        busy_cnt <= 8'(BUSY_MAX));
endmodule

bind ckm_clk_switch ckm_clk_switch_chk u_chk (
    .clk_osc     (clk_osc),
    .rst         (rst),
    .osc_on      (osc_on),
    .pll_gate    (pll_gate),
    .busy        (busy),
    .tgt_pll     (tgt == ckm_pkg::SRC_PLL),
    .pll_on      (pll_on),
    .self_clk_req(self_clk_req),
    .stop_req    (stop_req),
    .osc_run     (osc_run)
);

// File: tb/ckm_clk_switch_test.sv
`timescale 1ns/1ps
module ckm_clk_switch_test;
    localparam int TMR_N = 2;

    logic clk_osc = 1'b0;
    logic clk_pll = 1'b0;
    logic rst = 1'b1;
    logic sel_pll = 1'b0;
    logic pll_en_req = 1'b1;
    logic self_clk_req = 1'b0;
    logic stop_req = 1'b0;
    logic wait_req = 1'b0;
    logic [TMR_N-1:0] tmr_en = '0;
    logic [TMR_N-1:0] tmr_wait_off = '0;
    logic [TMR_N-1:0] tmr_stop_keep = '0;
    logic sys_clk, bus_clk, busy, src_pll, pll_on;
    logic [TMR_N-1:0] tmr_clk;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;
    int glitch_n = 0;
    realtime last_t = 0.0;
    int sys_pos = 0;
    int bus_pos = 0;

    always #2.5 clk_osc = ~clk_osc;   // 200 MHz
    always #1.5 clk_pll = ~clk_pll;

    ckm_clk_switch #(.TMR_N(TMR_N)) uut (
        .clk_osc(clk_osc), .clk_pll(clk_pll), .rst(rst),
        .sel_pll(sel_pll), .pll_en_req(pll_en_req), .self_clk_req(self_clk_req),
        .stop_req(stop_req), .wait_req(wait_req),
        .tmr_en(tmr_en), .tmr_wait_off(tmr_wait_off), .tmr_stop_keep(tmr_stop_keep),
        .sys_clk(sys_clk), .bus_clk(bus_clk), .tmr_clk(tmr_clk),
        .busy(busy), .src_pll(src_pll), .pll_on(pll_on)
    );

    always @(sys_clk) begin
        if (last_t > 0.0 && ($realtime - last_t) < 1.4) glitch_n++;
        last_t = $realtime;
    end
    always @(posedge sys_clk) sys_pos++;
    always @(posedge bus_clk) bus_pos++;

    function automatic bit tmr_exp(bit en, bit wo, bit sk, bit w, bit s);
        return en && !(w && wo) && !(s && !sk);
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(posedge clk_osc);
        #0.25;
    endtask

    task automatic follow_check(bit exp_pll, string req);
        int bad = 0;
        for (int k = 0; k < 40; k++) begin
            logic e;
            e = exp_pll ? clk_pll : clk_osc;
            if (sys_clk !== e) bad++;
            #0.5;
        end
        check(bad == 0, req, "sys_clk source mismatches", bad, 0);
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 50) begin
            cyc(1);
            n++;
        end
        check(n <= 12, "R4", "switch length in osc cycles", n, 12);
    endtask

    task automatic stop_check(string req);
        int bad = 0;
        int moves = 0;
        logic b0;
        b0 = bus_clk;
        for (int k = 0; k < 40; k++) begin
            if (sys_clk !== 1'b0) bad++;
            if (bus_clk !== b0) moves++;
            #0.5;
        end
        check(bad == 0, req, "sys_clk high samples in stop", bad, 0);
        check(moves == 0, req, "bus_clk changes in stop", moves, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        #200000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int s0, b0, ds, db;
        int unsigned r;
        cyc(6);
        // R10: reset state
        check(bus_clk == 1'b0, "R10", "bus_clk in reset", bus_clk, 0);
        check(busy == 1'b0, "R10", "busy in reset", busy, 0);
        rst = 1'b0;
        cyc(1);
        check(src_pll == 1'b0, "R10", "src_pll after reset", src_pll, 0);
        check(pll_on == 1'b1, "R10", "pll_on after reset", pll_on, 1);
        check(busy == 1'b0, "R10", "busy after reset", busy, 0);
        follow_check(1'b0, "R1");

        // R7: bus divider on oscillator
        cyc(1);
        s0 = sys_pos; b0 = bus_pos;
        cyc(20);
        ds = sys_pos - s0; db = bus_pos - b0;
        check(ds == 20, "R7", "sys edges on osc", ds, 20);
        check(db == 10, "R7", "bus edges on osc", db, 10);

        // R1/R4: switch to PLL
        sel_pll = 1'b1;
        cyc(1);
        check(busy == 1'b1, "R4", "busy after select change", busy, 1);
        wait_idle();
        check(src_pll == 1'b1, "R1", "src_pll after switch", src_pll, 1);
        follow_check(1'b1, "R1");
        cyc(1);
        s0 = sys_pos; b0 = bus_pos;
        cyc(20);
        ds = sys_pos - s0; db = bus_pos - b0;
        check((ds - 2 * db) <= 1 && (2 * db - ds) <= 1, "R7", "bus vs sys edges on pll", db, ds / 2);

        // R2: disable blocked while PLL selected
        pll_en_req = 1'b0;
        cyc(3);
        check(pll_on == 1'b1, "R2", "pll_on with PLL selected", pll_on, 1);

        // R5: change during busy is deferred
        sel_pll = 1'b0;
        cyc(1);
        check(busy == 1'b1, "R5", "busy at first switch", busy, 1);
        sel_pll = 1'b1;
        wait_idle();
        check(src_pll == 1'b0, "R5", "first switch reached osc", src_pll, 0);
        cyc(1);
        check(busy == 1'b1, "R5", "deferred switch started", busy, 1);
        wait_idle();
        check(src_pll == 1'b1, "R5", "deferred switch reached pll", src_pll, 1);
        follow_check(1'b1, "R5");

        // R2: disable takes effect with oscillator settled
        sel_pll = 1'b0;
        cyc(1);
        wait_idle();
        cyc(2);
        check(pll_on == 1'b0, "R2", "pll_on after disable on osc", pll_on, 0);
        pll_en_req = 1'b1;
        cyc(1);
        check(pll_on == 1'b1, "R2", "pll_on re-enabled", pll_on, 1);
        follow_check(1'b0, "R1");

        // R6: self-clock forces PLL
        self_clk_req = 1'b1;
        cyc(1);
        wait_idle();
        check(src_pll == 1'b1, "R6", "src_pll with self-clock", src_pll, 1);
        follow_check(1'b1, "R6");
        self_clk_req = 1'b0;
        cyc(1);
        wait_idle();
        check(src_pll == 1'b0, "R6", "src_pll after self-clock", src_pll, 0);

        // R8: stop on oscillator and on PLL
        stop_req = 1'b1;
        cyc(3);
        stop_check("R8");
        stop_req = 1'b0;
        cyc(3);
        follow_check(1'b0, "R8");
        sel_pll = 1'b1;
        cyc(1);
        wait_idle();
        stop_req = 1'b1;
        cyc(3);
        stop_check("R8");
        stop_req = 1'b0;
        cyc(3);
        follow_check(1'b1, "R8");
        sel_pll = 1'b0;
        cyc(1);
        wait_idle();

        // R9: timer gates under random mode bits
        r = $urandom(32'h1d5);
        for (int it = 0; it < 24; it++) begin
            r = $urandom;
            tmr_en = r[1:0];
            tmr_wait_off = r[3:2];
            tmr_stop_keep = r[5:4];
            wait_req = r[6];
            stop_req = r[7];
            cyc(2);
            for (int i = 0; i < TMR_N; i++) begin
                bit e;
                e = tmr_exp(tmr_en[i], tmr_wait_off[i], tmr_stop_keep[i], wait_req, stop_req);
                check(tmr_clk[i] == e, "R9", $sformatf("tmr_clk[%0d] with osc high", i), tmr_clk[i], e);
            end
            #2.5;
            check(tmr_clk == '0, "R9", "tmr_clk with osc low", tmr_clk, 0);
        end
        stop_req = 1'b0;
        wait_req = 1'b0;
        cyc(3);

        // R3: no short phases across all scenarios
        check(glitch_n == 0, "R3", "short sys_clk phases", glitch_n, 0);
        finish_run();
    end
endmodule